// File: doc/BRIEF.md
# Serial-Load Parallel Output Expander

This block turns a slow serial stream into a parallel output word. It is built from two registers, each with its own strobe. A rising edge on the shift strobe pushes one serial bit into a chain of stages. A rising edge on the latch strobe copies the whole chain into a storage register. The storage register drives the parallel outputs, so those outputs change only when a word has been committed, never while bits are still moving through the chain. The parallel outputs can be disabled as a group, which models a three-state bus. The serial output always shows the last stage of the chain, so several instances can be cascaded into one longer chain. A typical use is a host that drives SPI-style clock, data and chip-select lines to control a bank of outputs.

All five control and data inputs are sampled on a fast system clock. Each input passes through a two-flop synchronizer. The two strobes are then edge-detected. The serial data is delayed by the same number of flops as the shift strobe, so the two stay aligned. An active-low clear empties the chain and leaves the storage register alone. A synchronous active-high system reset clears everything.

Top module: `serial_latch_expander`

## Requirements
- R1: Take an input level that is present at system clock edge k. If it completes a low-to-high change of the shift strobe, the chain advances at edge k+2. Stage 0 takes the serial data that was present at edge k, and each stage i takes the old value of stage i-1.
- R2: A low-to-high change of the latch strobe copies all chain stages into the storage register at edge k+2. The parallel data output shows the storage register one edge later, at edge k+3.
- R3: When both strobes rise in the same sampling cycle, the storage register captures the chain contents from before that cycle's shift.
- R4: The clear input is active low. While it reads low (with the same two-edge delay), every chain stage is zero, the serial output is low, and a shift strobe has no effect. The storage register and the parallel data keep their values.
- R5: When the output-enable input is high, all bits of the parallel enable vector are 0 from edge k+2. When it is low, all bits are 1. The enable vector never has mixed bits.
- R6: The serial output always equals the last chain stage, whatever the output-enable input is doing.
- R7: A strobe held high causes exactly one action. When no rising strobe edge occurs, both registers hold their contents.
- R8: While the synchronous system reset is high, the chain, the storage register, the parallel data and the parallel enable vector are all zero.
- R9: Two instances, with the serial output of the first feeding the serial input of the second, behave as one 16-bit chain. For this to work, rising shift edges must be at least 3 system cycles apart. After 16 shifts and a latch, the concatenation {second, first} of the parallel data equals the 16 bits, with the first bit sent at bit 15.
- R10: Parallel bit 0 maps to the first chain stage. After 8 shifts, the first bit sent appears at bit 7 and the last bit sent appears at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high system reset |
| shift_strobe_i | input | 1 | Shift strobe; rising edge advances the chain |
| latch_strobe_i | input | 1 | Latch strobe; rising edge commits the chain to storage |
| ser_data_i | input | 1 | Serial data bit |
| clear_n_i | input | 1 | Active-low clear of the chain only |
| oe_n_i | input | 1 | Active-low enable of the parallel outputs |
| par_data_o | output | WIDTH | Registered copy of the storage register |
| par_en_o | output | WIDTH | Per-bit drive enable (1 = driven, 0 = high impedance) |
| ser_out_o | output | 1 | Last chain stage, for cascading |

## Verification
The bench runs several kinds of stimulus.

- **Fixed bytes.** Known bytes are shifted in with clean strobe pulses. These separate a correct bit order and stage direction from reversed or off-by-one chains.
- **Held strobe.** A strobe held high for many cycles tells real edge detection apart from level sensing.
- **Coincident strobes.** Edges on both strobes in the same cycle show whether the storage register captures the chain before or after the shift.
- **Clear during shifting.** Clear pulses interleaved with shift edges show whether the clear dominates and whether the storage register is spared.
- **Random inputs.** Long random input sequences are compared on every clock against a behavioural model.
- **Two-instance chain.** A cascaded pair exposes any misalignment between the delayed data and the detected strobe edge.

// File: rtl/sle_pkg.sv
package sle_pkg;

  localparam int SLE_SYNC_DEPTH = 2;

  // Control bundle after synchronization and edge detection
  typedef struct packed {
    logic shift_rise;
    logic latch_rise;
    logic clr_n;
    logic oe_n;
    logic data;
  } sle_ctl_t;

endpackage

// File: rtl/sle_sync.sv
module sle_sync #(
  parameter int              N       = 5,
  parameter int              STAGES  = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  logic [STAGES-1:0][N-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sle_edge.sv
module sle_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      // R7: a level held high yields a single-cycle pulse
      a_r7_single_pulse : assert property (@(posedge clk) disable iff (rst)
        rise_o[i] |=> !rise_o[i]);
    end
  endgenerate

endmodule

// File: rtl/sle_shift_chain.sv
module sle_shift_chain #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n_i,
  input  logic             shift_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] stages_o
);

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] moved;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign moved[i] = din_i;
      end else begin : g_body
        assign moved[i] = stage_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           stage_q <= '0;
    else if (!clr_n_i) stage_q <= '0;
    else if (shift_i)  stage_q <= moved;
  end

  assign stages_o = stage_q;

  // R1: stages move up by one on a shift
  a_r1_advance : assert property (@(posedge clk) disable iff (rst)
    (shift_i && clr_n_i) |=> (stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0])));
  // R4: clear empties the chain
  a_r4_clear_zero : assert property (@(posedge clk) disable iff (rst)
    !clr_n_i |=> (stage_q == '0));
  // R7: no shift edge, no change
  a_r7_chain_hold : assert property (@(posedge clk) disable iff (rst)
    (!shift_i && clr_n_i) |=> $stable(stage_q));

endmodule

// File: rtl/sle_hold.sv
module sle_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic [WIDTH-1:0] stages_i,
  input  logic             oe_n_i,
  output logic [WIDTH-1:0] par_data_o,
  output logic [WIDTH-1:0] par_en_o
);

  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      par_data_o <= '0;
      par_en_o   <= '0;
    end else begin
      if (capture_i) hold_q <= stages_i;
      par_data_o <= hold_q;
      par_en_o   <= {WIDTH{~oe_n_i}};
    end
  end

  // R2: capture copies the chain
  a_r2_capture : assert property (@(posedge clk) disable iff (rst)
    capture_i |=> (hold_q == $past(stages_i)));
  // R7: storage holds without a latch edge
  a_r7_store_keep : assert property (@(posedge clk) disable iff (rst)
    !capture_i |=> $stable(hold_q));
  // R5: disabled outputs all float
  a_r5_float : assert property (@(posedge clk) disable iff (rst)
    oe_n_i |=> (par_en_o == '0));

endmodule

// File: rtl/serial_latch_expander.sv
module serial_latch_expander
  import sle_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = SLE_SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_strobe_i,
  input  logic             latch_strobe_i,
  input  logic             ser_data_i,
  input  logic             clear_n_i,
  input  logic             oe_n_i,
  output logic [WIDTH-1:0] par_data_o,
  output logic [WIDTH-1:0] par_en_o,
  output logic             ser_out_o
);

  localparam int          NIN    = 5;
  // order: shift, latch, clear_n, oe_n, data
  localparam logic [NIN-1:0] IN_RST = 5'b00110;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] synced;
  logic [1:0]     rises;
  sle_ctl_t       ctl;
  logic [WIDTH-1:0] stages;

  assign raw_in = {shift_strobe_i, latch_strobe_i, clear_n_i, oe_n_i, ser_data_i};

  sle_sync #(.N(NIN), .STAGES(SYNC_DEPTH), .RST_VAL(IN_RST)) u_sync (
    .clk (clk), .rst (rst), .d_i (raw_in), .q_o (synced)
  );

  sle_edge #(.N(2)) u_edge (
    .clk (clk), .rst (rst), .lvl_i (synced[4:3]), .rise_o (rises)
  );

  always_comb begin
    ctl.shift_rise = rises[1];
    ctl.latch_rise = rises[0];
    ctl.clr_n      = synced[2];
    ctl.oe_n       = synced[1];
    ctl.data       = synced[0];
  end

  sle_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .clr_n_i  (ctl.clr_n),
    .shift_i  (ctl.shift_rise),
    .din_i    (ctl.data),
    .stages_o (stages)
  );

  sle_hold #(.WIDTH(WIDTH)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .capture_i  (ctl.latch_rise),
    .stages_i   (stages),
    .oe_n_i     (ctl.oe_n),
    .par_data_o (par_data_o),
    .par_en_o   (par_en_o)
  );

  assign ser_out_o = stages[WIDTH-1];

  // R4: serial output low after a clear
  a_r4_ser_low : assert property (@(posedge clk) disable iff (rst)
    !ctl.clr_n |=> !ser_out_o);
  // R5: enable vector is never mixed
  a_r5_uniform : assert property (@(posedge clk) disable iff (rst)
    (par_en_o == '0) || (par_en_o == '1));
  // R8: reset state of outputs
  a_r8_reset_out : assert property (@(posedge clk)
    rst |=> (par_data_o == '0 && par_en_o == '0 && !ser_out_o));

endmodule

// File: tb/serial_latch_expander_bench.sv
module serial_latch_expander_bench;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic i_sh = 0, i_lt = 0, i_d = 0, i_clr = 1, i_oe = 1;
  logic c_sh = 0, c_lt = 0, c_d = 0;
  logic [W-1:0] par_data, par_en, lo_par, lo_en, hi_par, hi_en;
  logic ser_out, lo_ser, hi_ser;

  int checks = 0;
  int fails  = 0;
  string tag = "R8";

  // behavioural model
  logic [W-1:0] m_sr = '0, m_hold = '0, m_pd = '0, m_pe = '0;
  logic [4:0] h1 = 5'b00110, h2 = 5'b00110, h3 = 5'b00110; // {sh,lt,clr,oe,d}

  always #2 clk = ~clk;

  serial_latch_expander #(.WIDTH(W)) u_serial_latch_expander (
    .clk(clk), .rst(rst), .shift_strobe_i(i_sh), .latch_strobe_i(i_lt),
    .ser_data_i(i_d), .clear_n_i(i_clr), .oe_n_i(i_oe),
    .par_data_o(par_data), .par_en_o(par_en), .ser_out_o(ser_out));

  serial_latch_expander #(.WIDTH(W)) u_casc_lo (
    .clk(clk), .rst(rst), .shift_strobe_i(c_sh), .latch_strobe_i(c_lt),
    .ser_data_i(c_d), .clear_n_i(1'b1), .oe_n_i(1'b0),
    .par_data_o(lo_par), .par_en_o(lo_en), .ser_out_o(lo_ser));

  serial_latch_expander #(.WIDTH(W)) u_casc_hi (
    .clk(clk), .rst(rst), .shift_strobe_i(c_sh), .latch_strobe_i(c_lt),
    .ser_data_i(lo_ser), .clear_n_i(1'b1), .oe_n_i(1'b0),
    .par_data_o(hi_par), .par_en_o(hi_en), .ser_out_o(hi_ser));

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [W-1:0] old_sr, old_hold;
    if (rst) begin
      m_sr = '0; m_hold = '0; m_pd = '0; m_pe = '0;
      h1 = 5'b00110; h2 = 5'b00110; h3 = 5'b00110;
    end else begin
      old_sr = m_sr; old_hold = m_hold;
      if (!h2[2])                 m_sr = '0;
      else if (h2[4] && !h3[4])   m_sr = {m_sr[W-2:0], h2[0]};
      if (h2[3] && !h3[3])        m_hold = old_sr;
      m_pd = old_hold;
      m_pe = h2[1] ? '0 : '1;
      h3 = h2; h2 = h1; h1 = {i_sh, i_lt, i_clr, i_oe, i_d};
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_edge();
      #1;
      chk({tag, "/R6"}, "ser_out", {15'd0, ser_out}, {15'd0, m_sr[W-1]});
      chk(tag, "par_data", {8'd0, par_data}, {8'd0, m_pd});
      chk({tag, "/R5"}, "par_en", {8'd0, par_en}, {8'd0, m_pe});
    end
  endtask

  task automatic shift_bit(input logic b);
    i_d = b; i_sh = 1; tick(2); i_sh = 0; tick(2);
  endtask

  task automatic latch_pulse();
    i_lt = 1; tick(2); i_lt = 0; tick(2);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [W-1:0] hold_before;
    logic [15:0]  word;
    // R8: reset state
    tag = "R8";
    tick(3);
    chk("R8", "par_data reset", {8'd0, par_data}, 16'd0);
    chk("R8", "par_en reset", {8'd0, par_en}, 16'd0);
    chk("R8", "ser_out reset", {15'd0, ser_out}, 16'd0);
    @(negedge clk); rst = 0; i_oe = 0;
    tick(4);

    // R1 / R10: byte order
    tag = "R10";
    for (int b = W - 1; b >= 0; b--) shift_bit(1'(8'hC5 >> b));
    latch_pulse();
    chk("R10", "byte order", {8'd0, par_data}, 16'h00C5);
    chk("R1", "last stage after 8 shifts", {15'd0, ser_out}, 16'd1);

    // R7: strobe held high shifts once
    tag = "R7";
    i_d = 0; i_sh = 1; tick(12); i_sh = 0; tick(3);
    i_lt = 1; tick(10); i_lt = 0; tick(3);
    chk("R7", "single shift while held", {8'd0, par_data}, 16'h008A);

    // R3: coincident strobes capture pre-shift contents
    tag = "R3";
    i_d = 1; i_sh = 1; i_lt = 1; tick(2); i_sh = 0; i_lt = 0; tick(3);
    chk("R3", "pre-shift capture", {8'd0, par_data}, 16'h008A);
    latch_pulse();
    chk("R3", "shift did occur", {8'd0, par_data}, 16'h0015);

    // R4: clear spares storage and blocks shifts
    tag = "R4";
    hold_before = par_data;
    i_clr = 0; i_d = 1; i_sh = 1; tick(2); i_sh = 0; tick(2);
    chk("R4", "ser_out under clear", {15'd0, ser_out}, 16'd0);
    chk("R4", "storage kept", {8'd0, par_data}, {8'd0, hold_before});
    i_clr = 1; tick(3);
    latch_pulse();
    chk("R4", "chain empty after clear", {8'd0, par_data}, 16'd0);

    // R5 / R6: output enable gates only the parallel side
    tag = "R5";
    for (int b = 0; b < W; b++) shift_bit(1'b1);
    i_oe = 1; tick(3);
    chk("R5", "par_en disabled", {8'd0, par_en}, 16'd0);
    chk("R6", "ser_out with oe high", {15'd0, ser_out}, 16'd1);
    i_oe = 0; tick(3);
    chk("R5", "par_en enabled", {8'd0, par_en}, 16'h00FF);

    // random patterns against the model
    tag = "R2";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      i_sh = 1'($urandom); i_lt = 1'($urandom); i_d = 1'($urandom);
      i_clr = ($urandom % 8) != 0; i_oe = ($urandom % 6) == 0;
      tick(1);
    end
    i_sh = 0; i_lt = 0; i_clr = 1; i_oe = 0; tick(4);

    // R9: cascade of two instances
    tag = "R9";
    word = 16'hB38E;
    for (int b = 15; b >= 0; b--) begin
      c_d = word[b]; c_sh = 1; tick(2); c_sh = 0; tick(2);
    end
    c_lt = 1; tick(2); c_lt = 0; tick(3);
    chk("R9", "16-bit chain", {hi_par, lo_par}, word);

    // R8: reset mid-run
    tag = "R8";
    @(negedge clk); rst = 1; tick(2);
    chk("R8", "par_data after reset", {8'd0, par_data}, 16'd0);
    chk("R8", "cascade cleared", {hi_par, lo_par}, 16'd0);
    finish_up();
  end

endmodule